// File: doc/BRIEF.md
# SPI Register-Poll Slave Responder

This block is an SPI slave for a host that keeps polling a bank of 24-bit registers. Every transaction is a fixed ten-byte exchange in both directions at once, framed by an active-low chip select. The host's first five bytes form a write vector and its sixth byte names a register. The trailing four host bytes only clock the reply out. The slave answers with a configurable idle byte, then echoes the five write-vector bytes one slot late. A constant 0xFF filler comes next, and the reply ends with the selected register's value, most significant byte first.

The SPI pins are brought into a free-running system clock through a synchroniser chain and edge detectors. All protocol logic runs in that clock domain. Once the register-number byte has arrived, the block pulses a one-cycle strobe. With it come the captured 40-bit write vector and 8-bit register number. The same pulse issues a read on a simple lookup port. That port must return data one system cycle after the request, and the filler slot hides this latency. Each SCK phase must last at least four system cycles more than the synchroniser depth. The bus uses SPI mode 0, MSB first.

Top module: `regpoll_spi_slave`

## Requirements
- R1: A frame is exactly ten bytes, shifted in on rising SCK edges and out on falling edges, MSB first; bytes beyond the tenth are not counted.
- R2: Response byte 0 equals the parameter IDLE_BYTE.
- R3: Response bytes 1 to 5 equal request bytes 0 to 4 of the same frame, in order.
- R4: Response byte 6 is always 0xFF, whatever register number was sent.
- R5: Response bytes 7, 8 and 9 carry bits 23:16, 15:8 and 7:0 of the value returned on rd_data for the register named by request byte 5.
- R6: Request bytes 6 to 9 have no effect on the response, on wvec or on regnum.
- R7: After request byte 5 is complete, frame_vld and rd_en pulse high for exactly one cycle, exactly once per frame. At that point wvec holds request bytes 0..4 (byte 0 in bits 39:32), and regnum and rd_addr hold request byte 5. These outputs keep their values until the next strobe.
- R8: Raising spi_csn at any point aborts the frame. A frame that ends before byte 5 completes gives no strobe, and the next frame starts again from byte 0.
- R9: spi_miso_oe is low whenever spi_csn is high and high whenever it is low.
- R10: A register bank that returns zero for every address yields zero in response bytes 7 to 9.
- R11: During reset, frame_vld and rd_en are low and wvec, regnum and rd_addr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_csn | input | 1 | Active-low chip select for this slave |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| frame_vld | output | 1 | One-cycle strobe when the register-number byte is captured |
| wvec | output | 40 | Captured write vector, request byte 0 in the top byte |
| regnum | output | 8 | Captured register number |
| rd_en | output | 1 | Register lookup request |
| rd_addr | output | 8 | Register lookup address |
| rd_data | input | 24 | Register value, valid one cycle after rd_en |

## Verification
The bench builds the block with IDLE_BYTE = 0xA5, so response byte 0 cannot be confused with an echo, the filler or a zero register value. It uses SYNC_STAGES = 3, one stage deeper than the default. That raises the pin-to-MISO latency, and the test shows that the lookup and each new MISO bit still settle within an eight-cycle SCK phase. Frames with varied dummy bytes, aborts before and during the register byte, and a bank that returns zeros are all reached with these settings.

// File: rtl/regpoll_pkg.sv
package regpoll_pkg;
  typedef logic [3:0] byte_idx_t;
  typedef logic [2:0] bit_idx_t;

  localparam int        VEC_BYTES   = 5;
  localparam int        DATA_BYTES  = 3;
  localparam int        VEC_W       = VEC_BYTES * 8;
  localparam int        DATA_W      = DATA_BYTES * 8;
  localparam byte_idx_t REG_IDX     = byte_idx_t'(VEC_BYTES);
  localparam byte_idx_t FILLER_IDX  = byte_idx_t'(VEC_BYTES + 1);
  localparam byte_idx_t DATA_IDX    = byte_idx_t'(VEC_BYTES + 2);
  localparam byte_idx_t FRAME_BYTES = byte_idx_t'(VEC_BYTES + 2 + DATA_BYTES);
  localparam logic [7:0] FILLER     = 8'hFF;
endpackage

// File: rtl/rp_sync.sv
module rp_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= RST_VAL;
    else        stg_q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= RST_VAL;
      else        stg_q[g] <= stg_q[g-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/rp_rx.sv
module rp_rx import regpoll_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             sck_rise,
  input  logic             mosi_s,
  output byte_idx_t        byte_cnt,
  output bit_idx_t         bit_cnt,
  output logic [VEC_W-1:0] vec_work,
  output logic             frame_vld,
  output logic [VEC_W-1:0] wvec,
  output logic [7:0]       regnum
);
  byte_idx_t        byte_q, byte_d;
  bit_idx_t         bit_q, bit_d;
  logic [7:0]       sh_q, sh_d, rx_byte;
  logic [VEC_W-1:0] work_q, work_d, wvec_q, wvec_d;
  logic [7:0]       reg_q, reg_d;
  logic             vld_q, vld_d;

  always_comb begin
    byte_d  = byte_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    work_d  = work_q;
    wvec_d  = wvec_q;
    reg_d   = reg_q;
    vld_d   = 1'b0;
    rx_byte = {sh_q[6:0], mosi_s};
    if (!cs_act) begin
      byte_d = '0;
      bit_d  = '0;
    end else if (sck_rise && (byte_q < FRAME_BYTES)) begin
      sh_d = rx_byte;
      if (bit_q == 3'd7) begin
        bit_d  = '0;
        byte_d = byte_q + 4'd1;
        for (int i = 0; i < VEC_BYTES; i++) begin
          if (byte_q == byte_idx_t'(i)) work_d[(VEC_BYTES-1-i)*8 +: 8] = rx_byte;
        end
        if (byte_q == REG_IDX) begin
          vld_d  = 1'b1;
          wvec_d = work_q;
          reg_d  = rx_byte;
        end
      end else begin
        bit_d = bit_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      work_q <= '0;
      wvec_q <= '0;
      reg_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      byte_q <= byte_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      work_q <= work_d;
      wvec_q <= wvec_d;
      reg_q  <= reg_d;
      vld_q  <= vld_d;
    end
  end

  assign byte_cnt  = byte_q;
  assign bit_cnt   = bit_q;
  assign vec_work  = work_q;
  assign frame_vld = vld_q;
  assign wvec      = wvec_q;
  assign regnum    = reg_q;

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  assert_strobe_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (byte_q == REG_IDX + 4'd1) && (bit_q == '0));
  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (byte_q == '0) && (bit_q == '0));
  assert_frame_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_q <= FRAME_BYTES);
endmodule

// File: rtl/rp_tx.sv
module rp_tx import regpoll_pkg::*; #(
  parameter logic [7:0] IDLE_BYTE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic              sck_fall,
  input  byte_idx_t         byte_cnt,
  input  bit_idx_t          bit_cnt,
  input  logic [VEC_W-1:0]  vec_work,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso_bit
);
  logic [7:0]        tx_q, tx_d, sel;
  logic [DATA_W-1:0] data_q, data_d;
  logic              pend_q, pend_d;

  always_comb begin
    sel = FILLER;
    for (int i = 1; i <= VEC_BYTES; i++) begin
      if (byte_cnt == byte_idx_t'(i)) sel = vec_work[(VEC_BYTES-i)*8 +: 8];
    end
    for (int j = 0; j < DATA_BYTES; j++) begin
      if (byte_cnt == DATA_IDX + byte_idx_t'(j)) sel = data_q[(DATA_BYTES-1-j)*8 +: 8];
    end
  end

  always_comb begin
    tx_d   = tx_q;
    pend_d = rd_en;
    data_d = pend_q ? rd_data : data_q;
    if (cs_start) begin
      tx_d = IDLE_BYTE;
    end else if (cs_act && sck_fall) begin
      if ((bit_cnt == '0) && (byte_cnt != '0) && (byte_cnt < FRAME_BYTES)) tx_d = sel;
      else                                                              tx_d = {tx_q[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '1;
      data_q <= '0;
      pend_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      data_q <= data_d;
      pend_q <= pend_d;
    end
  end

  assign miso_bit = tx_q[7];

  assert_filler_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !cs_start && sck_fall && (bit_cnt == '0) && (byte_cnt == FILLER_IDX)) |=> (tx_q == FILLER));
  assert_lookup_in_filler_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (byte_cnt == FILLER_IDX));
endmodule

// File: rtl/regpoll_spi_slave.sv
module regpoll_spi_slave import regpoll_pkg::*; #(
  parameter logic [7:0] IDLE_BYTE   = 8'h00,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              frame_vld,
  output logic [VEC_W-1:0]  wvec,
  output logic [7:0]        regnum,
  output logic              rd_en,
  output logic [7:0]        rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  logic [2:0] pins_s;
  logic       csn_s, sck_s, mosi_s;
  logic       csn_q, sck_q;
  logic       cs_act, cs_start, sck_rise, sck_fall;
  byte_idx_t        byte_cnt;
  bit_idx_t         bit_cnt;
  logic [VEC_W-1:0] vec_work;
  logic             vld;
  logic [7:0]       reg_num;

  rp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_csn, spi_sck, spi_mosi}),
    .dout (pins_s)
  );
  assign {csn_s, sck_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      csn_q <= csn_s;
      sck_q <= sck_s;
    end
  end

  assign cs_act   = !csn_s;
  assign cs_start = !csn_s && csn_q;
  assign sck_rise = sck_s && !sck_q;
  assign sck_fall = !sck_s && sck_q;

  rp_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .sck_rise (sck_rise),
    .mosi_s   (mosi_s),
    .byte_cnt (byte_cnt),
    .bit_cnt  (bit_cnt),
    .vec_work (vec_work),
    .frame_vld(vld),
    .wvec     (wvec),
    .regnum   (reg_num)
  );

  rp_tx #(.IDLE_BYTE(IDLE_BYTE)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_act  (cs_act),
    .cs_start(cs_start),
    .sck_fall(sck_fall),
    .byte_cnt(byte_cnt),
    .bit_cnt (bit_cnt),
    .vec_work(vec_work),
    .rd_en   (vld),
    .rd_data (rd_data),
    .miso_bit(spi_miso)
  );

  assign spi_miso_oe = !spi_csn;
  assign frame_vld   = vld;
  assign rd_en       = vld;
  assign regnum      = reg_num;
  assign rd_addr     = reg_num;
endmodule

// File: tb/sim_regpoll_spi_slave.sv
module sim_regpoll_spi_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [7:0] IDLE = 8'hA5;

  logic        clk, rst_n, spi_sck, spi_csn, spi_mosi;
  logic        spi_miso, spi_miso_oe, frame_vld, rd_en;
  logic [39:0] wvec;
  logic [7:0]  regnum, rd_addr;
  logic [23:0] rd_data;

  int n_chk, n_fail, vld_cnt, rd_cnt;
  logic        zero_bank;
  logic [39:0] cap_wvec;
  logic [7:0]  cap_reg, cap_addr;
  logic [7:0]  req [10];
  logic [7:0]  rsp [10];
  logic        oe_seen_low;

  regpoll_spi_slave #(.IDLE_BYTE(IDLE), .SYNC_STAGES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .frame_vld(frame_vld), .wvec(wvec), .regnum(regnum),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] model(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5A};
  endfunction

  initial rd_data = '0;
  always @(posedge clk) begin
    if (rd_en) begin
      rd_data  <= zero_bank ? 24'h0 : model(rd_addr);
      rd_cnt   <= rd_cnt + 1;
      cap_addr <= rd_addr;
    end
    if (frame_vld) begin
      vld_cnt  <= vld_cnt + 1;
      cap_wvec <= wvec;
      cap_reg  <= regnum;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int nbytes, input int extra_bits);
    oe_seen_low = 1'b0;
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbytes; b++) begin
      for (int i = 7; i >= 0; i--) begin
        spi_mosi = req[b][i];
        repeat (HALF) @(negedge clk);
        rsp[b][i] = spi_miso;
        if (!spi_miso_oe) oe_seen_low = 1'b1;
        spi_sck = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sck = 1'b0;
      end
    end
    for (int i = 0; i < extra_bits; i++) begin
      spi_mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic set_req(input logic [39:0] v, input logic [7:0] r, input logic [31:0] dum);
    for (int i = 0; i < 5; i++) req[i] = v[(4-i)*8 +: 8];
    req[5] = r;
    for (int i = 0; i < 4; i++) req[6+i] = dum[(3-i)*8 +: 8];
  endtask

  task automatic full_frame(input logic [39:0] v, input logic [7:0] r,
                            input logic [31:0] dum, input string dtag);
    int v0, r0;
    logic [23:0] val;
    v0 = vld_cnt; r0 = rd_cnt;
    set_req(v, r, dum);
    xfer(10, 0);
    val = zero_bank ? 24'h0 : model(r);
    check("R2 byte0", rsp[0], IDLE);
    for (int i = 1; i <= 5; i++) check("R3 echo", rsp[i], req[i-1]);
    check("R4 filler", rsp[6], 8'hFF);
    check({dtag, " data hi"},  rsp[7], val[23:16]);
    check({dtag, " data mid"}, rsp[8], val[15:8]);
    check({dtag, " data lo"},  rsp[9], val[7:0]);
    check("R7 one strobe", vld_cnt - v0, 1);
    check("R7 one lookup", rd_cnt - r0, 1);
    check("R7 wvec at strobe", cap_wvec, v);
    check("R7 regnum at strobe", cap_reg, r);
    check("R7 rd_addr", cap_addr, r);
    check("R7 wvec held", wvec, v);
    check("R9 oe high in frame", oe_seen_low, 1'b0);
    check("R9 oe low idle", spi_miso_oe, 1'b0);
  endtask

  task automatic t_reset();
    check("R11 frame_vld", frame_vld, 0);
    check("R11 rd_en", rd_en, 0);
    check("R11 wvec", wvec, 0);
    check("R11 regnum", regnum, 0);
    check("R11 rd_addr", rd_addr, 0);
    check("R9 oe in reset", spi_miso_oe, 0);
  endtask

  task automatic t_basic();
    full_frame(40'h11_22_33_44_55, 8'h3C, 32'h0, "R5");
    full_frame(40'hF0_0F_80_01_7E, 8'hC3, 32'h0, "R1 R5");
  endtask

  task automatic t_dummies();
    full_frame(40'hDE_AD_BE_EF_01, 8'h42, 32'hFF_FF_FF_FF, "R6");
    full_frame(40'hDE_AD_BE_EF_01, 8'h42, 32'h99_00_A5_5A, "R6");
    check("R6 regnum not from dummy", regnum, 8'h42);
    check("R6 wvec not from dummy", wvec, 40'hDE_AD_BE_EF_01);
  endtask

  task automatic t_abort();
    int v0;
    v0 = vld_cnt;
    set_req(40'h01_02_03_04_05, 8'h77, 32'h0);
    xfer(3, 0);
    check("R8 no strobe 3 bytes", vld_cnt - v0, 0);
    xfer(5, 5);
    check("R8 no strobe mid reg byte", vld_cnt - v0, 0);
    check("R8 outputs kept", regnum, 8'h42);
    full_frame(40'hAA_BB_CC_DD_EE, 8'h10, 32'h0, "R8");
  endtask

  task automatic t_zero_bank();
    zero_bank = 1'b1;
    full_frame(40'h12_34_56_78_9A, 8'hFE, 32'h0, "R10");
    zero_bank = 1'b0;
  endtask

  task automatic t_long();
    int v0;
    v0 = vld_cnt;
    set_req(40'h5A_A5_3C_C3_00, 8'h01, 32'h0);
    xfer(10, 16);
    check("R1 extra bits no strobe", vld_cnt - v0, 1);
    full_frame(40'h00_00_00_00_00, 8'h00, 32'h0, "R1 R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; vld_cnt = 0; rd_cnt = 0;
    zero_bank = 1'b0;
    cap_wvec = '0; cap_reg = '0; cap_addr = '0;
    rst_n = 1'b0; spi_csn = 1'b1; spi_sck = 1'b0; spi_mosi = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_basic();
    t_dummies();
    t_abort();
    t_zero_bank();
    t_long();
    summary();
    $finish;
  end
endmodule